// File: doc/BRIEF.md
# Link Status Blink-Code Indicator

This block drives one active-low status pin from a small link-state code. A healthy link holds the pin low. An empty port holds it high. A failed link makes the pin flash a repeating burst of fixed-width low pulses, and the number of pulses in the burst names the failure class.

A prescaler turns the reference clock into a one-millisecond tick. Every burst length and gap is counted in those ticks. A parameter sets the prescale ratio, so a testbench can make the millisecond short. The block does not detect failures. Whatever logic owns the link supplies the state code and a one-cycle strobe when a device is plugged in.

The state code and the strobe are plain control inputs. They are sampled on every clock and carry no handshake, so there is no back-pressure to manage.

Top module: `link_blink_top`

## Requirements
- R1: During and right after reset, `status_n` is 1.
- R2: When `link_state` is 1 (connected), `status_n` is 0 on the clock after the code is sampled. This holds even in the middle of a burst gap.
- R3: Code 0 (disconnected) and the unused codes 5, 6 and 7 hold `status_n` at 1 with no pulses.
- R4: Code 2 (not responding) gives a burst of one low pulse that is `PULSE_MS` ticks wide (50 ms by default).
- R5: Code 3 (not supported) gives two low pulses. The two pulses are separated by a high gap that is `PULSE_MS` ticks long.
- R6: Code 4 (hub not supported) gives three low pulses, each pair separated by a `PULSE_MS` high gap.
- R7: A burst repeats every `PERIOD_MS` ticks (1000 ms by default), measured from the start of one burst to the start of the next.
- R8: If the code changes during a burst, the burst stops at once and the pin goes high. The new code's pattern starts on the next tick.
- R9: A `plug_evt` strobe while an error code is present restarts the burst from its first pulse on the next tick.
- R10: The millisecond tick is a one-cycle strobe every `TICK_CYCLES` clocks (12000 at 12 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (12 MHz by default) |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_state | input | 3 | Link state code: 0 disconnected, 1 connected, 2 not responding, 3 not supported, 4 hub not supported |
| plug_evt | input | 1 | One-cycle strobe marking a plug-in event |
| status_n | output | 1 | Active-low status pin |

## Verification
The bench counts pulses by sampling the middle of every 50 ms slot for each of the three error codes. A design that miscounts slots would show a missing pulse or an extra pulse in the burst.

It also samples one full period later, at the start of the next burst. A period counter that is off by one slot, or that never wraps, would put that first pulse in the wrong place.

Some checks change the state in mid-burst: from an error code to connected during a gap, and from a three-pulse code to a one-pulse code during a low pulse. A design that finished the old burst, or let the old slot position leak into the new pattern, would show pulses in the wrong slots.

An unused code and a plug strobe late in the period are also covered. These catch a decoder that treats reserved codes as errors, and a restart that waits for the period to wrap.

// File: rtl/link_blink_pkg.sv
package link_blink_pkg;

  typedef enum logic [2:0] {
    CL_OFF = 3'd0,
    CL_ON  = 3'd1,
    CL_E1  = 3'd2,
    CL_E2  = 3'd3,
    CL_E3  = 3'd4
  } link_cls_e;

  // Map the raw code to a class; reserved codes fall back to disconnected.
  function automatic link_cls_e decode_state(input logic [2:0] code);
    case (code)
      3'd1:    decode_state = CL_ON;
      3'd2:    decode_state = CL_E1;
      3'd3:    decode_state = CL_E2;
      3'd4:    decode_state = CL_E3;
      default: decode_state = CL_OFF;
    endcase
  endfunction

  function automatic logic is_error(input link_cls_e c);
    is_error = (c == CL_E1) || (c == CL_E2) || (c == CL_E3);
  endfunction

  function automatic int pulse_count(input link_cls_e c);
    case (c)
      CL_E1:   pulse_count = 1;
      CL_E2:   pulse_count = 2;
      CL_E3:   pulse_count = 3;
      default: pulse_count = 0;
    endcase
  endfunction

endpackage

// File: rtl/link_blink_tick.sv
module link_blink_tick #(
  parameter int TICK_CYCLES = 12000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // R10
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (TICK_CYCLES > 1 && tick) |=> !tick);

endmodule

// File: rtl/link_blink_seq.sv
module link_blink_seq
  import link_blink_pkg::*;
#(
  parameter int PULSE_MS  = 50,
  parameter int PERIOD_MS = 1000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  link_cls_e cls,
  input  logic      plug,
  output logic      level
);
  localparam int SLOTS = PERIOD_MS / PULSE_MS;
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int PW    = (PULSE_MS > 1) ? $clog2(PULSE_MS) : 1;
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
  localparam logic [PW-1:0] SUB_LAST  = PW'(PULSE_MS - 1);

  link_cls_e     cls_q;
  logic          armed;
  logic          running;
  logic [PW-1:0] sub;
  logic [SW-1:0] slot;
  logic          changed;

  assign changed = (cls != cls_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q   <= CL_OFF;
      armed   <= 1'b0;
      running <= 1'b0;
      sub     <= '0;
      slot    <= '0;
    end else begin
      cls_q <= cls;
      if (changed) begin
        running <= 1'b0;
        armed   <= is_error(cls);
      end else if (plug && is_error(cls)) begin
        running <= 1'b0;
        armed   <= 1'b1;
      end else if (tick) begin
        if (armed) begin
          armed   <= 1'b0;
          running <= 1'b1;
          sub     <= '0;
          slot    <= '0;
        end else if (running) begin
          if (sub == SUB_LAST) begin
            sub  <= '0;
            slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    case (cls)
      CL_ON:  level = 1'b0;
      CL_OFF: level = 1'b1;
      default:
        level = !(!changed && running && !slot[0] &&
                  (int'(slot) < 2 * pulse_count(cls)));
    endcase
  end

  // R8
  abort_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> !running);

  // R9
  plug_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!changed && plug && is_error(cls)) |=> (!running && armed));

  // R7
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (int'(slot) < SLOTS));

endmodule

// File: rtl/link_blink_top.sv
module link_blink_top
  import link_blink_pkg::*;
#(
  parameter int TICK_CYCLES = 12000,
  parameter int PULSE_MS    = 50,
  parameter int PERIOD_MS   = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] link_state,
  input  logic       plug_evt,
  output logic       status_n
);
  logic      tick;
  logic      level;
  link_cls_e cls;

  assign cls = decode_state(link_state);

  link_blink_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  link_blink_seq #(.PULSE_MS(PULSE_MS), .PERIOD_MS(PERIOD_MS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .cls   (cls),
    .plug  (plug_evt),
    .level (level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_n <= 1'b1;
    else        status_n <= level;
  end

  // R2
  connected_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 3'd1) |=> !status_n);

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 3'd0 || link_state > 3'd4) |=> status_n);

endmodule

// File: tb/test_link_blink_top.sv
module test_link_blink_top;
  localparam int TK = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] link_state = 3'd0;
  logic       plug_evt = 1'b0;
  logic       status_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  link_blink_top #(.TICK_CYCLES(TK), .PULSE_MS(50), .PERIOD_MS(1000)) i_link_blink_top (
    .clk(clk), .rst_n(rst_n), .link_state(link_state),
    .plug_evt(plug_evt), .status_n(status_n)
  );

  // entry: {new_group, state, ms offset from burst start, expected pin}
  localparam int NV = 26;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 3'd2, 11'd25,   1'b0},  // R4
    {1'b0, 3'd2, 11'd75,   1'b1},
    {1'b0, 3'd2, 11'd125,  1'b1},
    {1'b0, 3'd2, 11'd175,  1'b1},
    {1'b0, 3'd2, 11'd525,  1'b1},
    {1'b0, 3'd2, 11'd1025, 1'b0},  // R7
    {1'b0, 3'd2, 11'd1075, 1'b1},
    {1'b1, 3'd3, 11'd25,   1'b0},  // R5
    {1'b0, 3'd3, 11'd75,   1'b1},
    {1'b0, 3'd3, 11'd125,  1'b0},
    {1'b0, 3'd3, 11'd175,  1'b1},
    {1'b0, 3'd3, 11'd225,  1'b1},
    {1'b0, 3'd3, 11'd1125, 1'b0},  // R7
    {1'b1, 3'd4, 11'd25,   1'b0},  // R6
    {1'b0, 3'd4, 11'd75,   1'b1},
    {1'b0, 3'd4, 11'd125,  1'b0},
    {1'b0, 3'd4, 11'd175,  1'b1},
    {1'b0, 3'd4, 11'd225,  1'b0},
    {1'b0, 3'd4, 11'd275,  1'b1},
    {1'b0, 3'd4, 11'd325,  1'b1},
    {1'b0, 3'd4, 11'd1225, 1'b0},  // R7
    {1'b1, 3'd6, 11'd25,   1'b1},  // R3
    {1'b0, 3'd6, 11'd125,  1'b1},
    {1'b1, 3'd0, 11'd25,   1'b1},  // R3
    {1'b1, 3'd1, 11'd25,   1'b0},  // R2
    {1'b0, 3'd1, 11'd525,  1'b0}
  };

  task automatic check(input string req, input logic exp);
    checks++;
    if (status_n !== exp) begin
      errors++;
      $display("FAIL %s: status_n=%b expected %b at cycle %0d", req, status_n, exp, cyc);
    end
  endtask

  function automatic string req_of(input logic [2:0] st);
    case (st)
      3'd1: return "R2";
      3'd2: return "R4/R7";
      3'd3: return "R5/R7";
      3'd4: return "R6/R7";
      default: return "R3";
    endcase
  endfunction

  task automatic start_state(input logic [2:0] st, output int base);
    @(posedge clk); #1;
    link_state = st;
    plug_evt = 1'b1;
    base = cyc;
    @(posedge clk); #1;
    plug_evt = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int base;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 1'b1);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check("R1", 1'b1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][15]) start_state(VEC[i][14:12], base);
      wait_until(base + 4 + int'(VEC[i][11:1]) * TK);
      check(req_of(VEC[i][14:12]), VEC[i][0]);
    end

    // R2: connected in the middle of a gap of a two-pulse burst
    start_state(3'd3, base);
    wait_until(base + 4 + 75 * TK);
    check("R5", 1'b1);
    link_state = 3'd1;
    repeat (2) @(posedge clk);
    #1;
    check("R2", 1'b0);

    // R8: three-pulse burst cut during its first pulse by a one-pulse code
    start_state(3'd4, base);
    wait_until(base + 4 + 25 * TK);
    check("R6", 1'b0);
    link_state = 3'd2;
    base = cyc;
    repeat (2) @(posedge clk);
    #1;
    check("R8", 1'b1);
    wait_until(base + 4 + 25 * TK);
    check("R8", 1'b0);
    wait_until(base + 4 + 125 * TK);
    check("R8", 1'b1);
    wait_until(base + 4 + 225 * TK);
    check("R8", 1'b1);

    // R9: plug strobe late in the period restarts the burst
    wait_until(base + 4 + 500 * TK);
    check("R9", 1'b1);
    @(posedge clk); #1;
    plug_evt = 1'b1;
    base = cyc;
    @(posedge clk); #1;
    plug_evt = 1'b0;
    wait_until(base + 4 + 25 * TK);
    check("R9", 1'b0);
    wait_until(base + 4 + 75 * TK);
    check("R9", 1'b1);

    // R1: reset in the middle of a pulse
    wait_until(base + 4 + 1025 * TK);
    check("R7", 1'b0);
    rst_n = 1'b0;
    #2;
    check("R1", 1'b1);
    link_state = 3'd0;
    @(posedge clk); #1;
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule